// File: doc/BRIEF.md
# Configurable Logic Tile with Directional Routing

This block is a single tile of a fine-grained reconfigurable fabric. Each of its four sides (north, east, south, west) brings in four signals: a neighbour's combinational result, a neighbour's registered result, a direct line and a distance-4 line. Two operand selectors pick from these sixteen signals (one selector can also pick a configured constant). An optional inversion and a small two-input function produce a combinational result. That result also feeds a D flip-flop. Each side has its own output selector. It drives either the tile's own results or a direct line passed through from one of the other three sides.

All selections live in a 31-bit configuration word. The word is shifted in serially and copied into a shadow stage by a load strobe, so a tile can be reprogrammed while it keeps working with its old setting. The shift output allows tiles to be chained. A two-bit usage mode switches off the parts of the tile that a given use does not need.

Top module: `cell_tile`

## Requirements
- R1: While reset is asserted and right after it, the flip-flop output and all four side outputs are 0, and the active configuration is all-zero.
- R2: On each clock with `cfg_en` high, the shift stage moves one place toward its MSB and takes `cfg_in` at bit 0. `cfg_out` always shows the shift stage's bit 30. Without `cfg_en`, the shift stage is unchanged.
- R3: Shifted bits have no effect on any output until a `cfg_load` clock copies the whole shift stage into the active stage.
- R4: Layout of the active word: sel_a [4:0], sel_b [8:5], invert_b [9], op [11:10], constant [12], mode [14:13], side s selector [15+3s +: 3], side s enable [27+s], with s = 0 north, 1 east, 2 south, 3 west.
- R5: Input index i = 4*side + line, where line 0 is the combinational signal, 1 the registered signal, 2 the direct line and 3 the distance-4 line. Operand A is input sel_a when sel_a < 16; otherwise it is the constant bit. Operand B is input sel_b, XORed with invert_b.
- R6: The core result is A AND B for op 0, A OR B for op 1, A XOR B for op 2 and A for op 3. `c_out` carries this result in modes 0 and 1 and is 0 in modes 2 and 3.
- R7: In modes 0, 1 and 2 the flip-flop loads the core result on each clock.
- R8: `ff_clr` high clears the flip-flop to 0 at the next clock in every mode and for any configuration.
- R9: Side selector codes: 0 selects the own core result, 1 the flip-flop output, 2, 3 and 4 the direct line (line 2) of side (s+1)%4, (s+2)%4 and (s+3)%4. Codes 5 to 7 give 0.
- R10: A side whose enable bit is 0 drives 0.
- R11: Mode 1 (logic only) forces pass-through codes 2 to 4 to give 0.
- R12: Mode 2 (sequential plus routing) forces code 0 on the sides to give 0.
- R13: Mode 3 (routing only) keeps the flip-flop at its value unless `ff_clr` is high, and forces codes 0 and 1 on the sides to give 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_north | input | 4 | North inputs {dist4, direct, registered, comb} |
| in_east | input | 4 | East inputs, same line order |
| in_south | input | 4 | South inputs, same line order |
| in_west | input | 4 | West inputs, same line order |
| cfg_en | input | 1 | Shift enable for the configuration stage |
| cfg_in | input | 1 | Serial configuration data |
| cfg_load | input | 1 | Copy shift stage into active stage |
| cfg_out | output | 1 | Serial output for chaining |
| ff_clr | input | 1 | Synchronous clear of the flip-flop |
| c_out | output | 1 | Gated combinational result |
| q_out | output | 1 | Flip-flop output |
| out_north | output | 1 | North side output |
| out_east | output | 1 | East side output |
| out_south | output | 1 | South side output |
| out_west | output | 1 | West side output |

## Verification
The assertions assume that `cfg_en`, `cfg_load` and `ff_clr` are clean levels sampled at the clock, and that a configuration change arrives only through a load. They also take the flip-flop's value in routing-only mode to be whatever it held before. The stimulus changes every input only in the low phase of the clock. It draws whole configuration words at random, so that all modes, codes and out-of-range selector values occur. Each word is shifted in fully before it is loaded. Directed sequences cover reset, idle shifting without enable, clear during hold mode and the constant operand.

// File: rtl/cell_tile_pkg.sv
package cell_tile_pkg;
  localparam int SIDES  = 4;
  localparam int LINES  = 4;
  localparam int NIN    = SIDES * LINES;
  localparam int SELB_W = $clog2(NIN);
  localparam int SELA_W = SELB_W + 1;
  localparam int OSEL_W = 3;
  localparam int DIR_LINE = 2;

  typedef enum logic [1:0] {MODE_FULL, MODE_LOGIC, MODE_SEQROUTE, MODE_ROUTE} mode_e;
  typedef enum logic [1:0] {OP_AND, OP_OR, OP_XOR, OP_PASS} op_e;

  typedef struct packed {
    logic [SIDES-1:0]             side_en;
    logic [SIDES-1:0][OSEL_W-1:0] side_sel;
    mode_e                        mode;
    logic                         konst;
    op_e                          op;
    logic                         inv_b;
    logic [SELB_W-1:0]            sel_b;
    logic [SELA_W-1:0]            sel_a;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/cell_cfg_chain.sv
module cell_cfg_chain #(
  parameter int W = 31
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  input  logic         load,
  output logic         dout,
  output logic [W-1:0] active
);
  logic [W-1:0] mst_q, mst_d, slv_q, slv_d;

  always_comb begin
    mst_d = mst_q;
    if (shift_en) mst_d = {mst_q[W-2:0], din};
    slv_d = slv_q;
    if (load) slv_d = mst_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst_q <= '0;
      slv_q <= '0;
    end else begin
      mst_q <= mst_d;
      slv_q <= slv_d;
    end
  end

  assign dout   = mst_q[W-1];
  assign active = slv_q;

  // R2: serial bit enters at position 0
  a_r2_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> mst_q[0] == $past(din));
  // R2: no movement without enable
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(mst_q));
  // R3: active stage changes only on load
  a_r3_slave_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(slv_q));
endmodule

// File: rtl/cell_core.sv
module cell_core
  import cell_tile_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NIN-1:0] in_bus,
  input  cfg_t           cfg,
  input  logic           srst,
  output logic           c_raw,
  output logic           c_out,
  output logic           q
);
  logic opa, opb, ff_en, q_q, q_d;

  always_comb begin
    opa = cfg.sel_a[SELA_W-1] ? cfg.konst : in_bus[cfg.sel_a[SELB_W-1:0]];
    opb = in_bus[cfg.sel_b] ^ cfg.inv_b;
    case (cfg.op)
      OP_AND:  c_raw = opa & opb;
      OP_OR:   c_raw = opa | opb;
      OP_XOR:  c_raw = opa ^ opb;
      default: c_raw = opa;
    endcase
    c_out = (cfg.mode == MODE_FULL || cfg.mode == MODE_LOGIC) ? c_raw : 1'b0;
  end

  always_comb begin
    ff_en = (cfg.mode != MODE_ROUTE);
    q_d   = q_q;
    if (srst)       q_d = 1'b0;
    else if (ff_en) q_d = c_raw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= 1'b0;
    else        q_q <= q_d;
  end

  assign q = q_q;

  // R7: flip-flop captures the core result when sequential part is on
  a_r7_q_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode != MODE_ROUTE && !srst) |=> q_q == $past(c_raw));
  // R8: clear wins in every mode
  a_r8_sync_clear: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> !q_q);
  // R13: hold in routing-only mode
  a_r13_ff_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode == MODE_ROUTE && !srst) |=> $stable(q_q));
endmodule

// File: rtl/cell_route.sv
module cell_route
  import cell_tile_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             own_c,
  input  logic             own_q,
  input  logic [SIDES-1:0] dir_in,
  input  cfg_t             cfg,
  output logic [SIDES-1:0] side_out
);
  logic c_ok, q_ok, pass_ok;

  always_comb begin
    c_ok    = (cfg.mode == MODE_FULL) || (cfg.mode == MODE_LOGIC);
    q_ok    = (cfg.mode != MODE_ROUTE);
    pass_ok = (cfg.mode != MODE_LOGIC);
  end

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    logic v;
    always_comb begin
      case (cfg.side_sel[s])
        3'd0:    v = c_ok & own_c;
        3'd1:    v = q_ok & own_q;
        3'd2:    v = pass_ok & dir_in[(s+1)%SIDES];
        3'd3:    v = pass_ok & dir_in[(s+2)%SIDES];
        3'd4:    v = pass_ok & dir_in[(s+3)%SIDES];
        default: v = 1'b0;
      endcase
      side_out[s] = cfg.side_en[s] & v;
    end

    // R11: logic-only mode never lets pass-through traffic out
    a_r11_no_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.mode == MODE_LOGIC && side_out[s]) |-> (cfg.side_sel[s] < 3'd2));
    // R13: routing-only mode never drives own results
    a_r13_no_own: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.mode == MODE_ROUTE && side_out[s]) |-> (cfg.side_sel[s] >= 3'd2));
  end
endmodule

// File: rtl/cell_tile.sv
module cell_tile
  import cell_tile_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] in_north,
  input  logic [3:0] in_east,
  input  logic [3:0] in_south,
  input  logic [3:0] in_west,
  input  logic       cfg_en,
  input  logic       cfg_in,
  input  logic       cfg_load,
  output logic       cfg_out,
  input  logic       ff_clr,
  output logic       c_out,
  output logic       q_out,
  output logic       out_north,
  output logic       out_east,
  output logic       out_south,
  output logic       out_west
);
  logic [1:0]       rst_sync;
  logic             rst_ni;
  logic [NIN-1:0]   in_bus;
  logic [CFG_W-1:0] cfg_bits;
  cfg_t             cfg;
  logic             c_raw;
  logic [SIDES-1:0] dir_in, side_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  assign in_bus = {in_west, in_south, in_east, in_north};
  assign cfg    = cfg_t'(cfg_bits);

  for (genvar s = 0; s < SIDES; s++) begin : g_dir
    assign dir_in[s] = in_bus[s*LINES + DIR_LINE];
  end

  cell_cfg_chain #(.W(CFG_W)) u_chain (
    .clk(clk), .rst_n(rst_ni), .shift_en(cfg_en), .din(cfg_in),
    .load(cfg_load), .dout(cfg_out), .active(cfg_bits)
  );

  cell_core u_core (
    .clk(clk), .rst_n(rst_ni), .in_bus(in_bus), .cfg(cfg), .srst(ff_clr),
    .c_raw(c_raw), .c_out(c_out), .q(q_out)
  );

  cell_route u_route (
    .clk(clk), .rst_n(rst_ni), .own_c(c_raw), .own_q(q_out),
    .dir_in(dir_in), .cfg(cfg), .side_out(side_out)
  );

  assign out_north = side_out[0];
  assign out_east  = side_out[1];
  assign out_south = side_out[2];
  assign out_west  = side_out[3];

  // R1: outputs quiet while reset is held
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_ni |-> (side_out == '0 && !q_out));
endmodule

// File: tb/tb_cell_tile.sv
module tb_cell_tile;
  logic clk = 1'b0;
  logic rst_n;
  logic [3:0] in_north, in_east, in_south, in_west;
  logic cfg_en, cfg_in, cfg_load, ff_clr;
  logic cfg_out, c_out, q_out, out_north, out_east, out_south, out_west;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [30:0] sh_m, act_m;
  logic q_m;

  always #5 clk = ~clk;

  cell_tile dut (
    .clk(clk), .rst_n(rst_n), .in_north(in_north), .in_east(in_east),
    .in_south(in_south), .in_west(in_west), .cfg_en(cfg_en), .cfg_in(cfg_in),
    .cfg_load(cfg_load), .cfg_out(cfg_out), .ff_clr(ff_clr), .c_out(c_out),
    .q_out(q_out), .out_north(out_north), .out_east(out_east),
    .out_south(out_south), .out_west(out_west)
  );

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] ibus();
    return {in_west, in_south, in_east, in_north};
  endfunction

  function automatic logic exp_core(logic [30:0] w, logic [15:0] ib);
    logic a, b;
    a = w[4] ? w[12] : ib[w[3:0]];
    b = ib[w[8:5]] ^ w[9];
    case (w[11:10])
      2'd0: return a & b;
      2'd1: return a | b;
      2'd2: return a ^ b;
      default: return a;
    endcase
  endfunction

  function automatic logic exp_side(logic [30:0] w, logic [15:0] ib, logic q, int s);
    logic [2:0] code;
    logic [1:0] md;
    int t;
    code = w[15+3*s +: 3];
    md   = w[14:13];
    if (!w[27+s]) return 1'b0;
    case (code)
      3'd0: return (md <= 2'd1) ? exp_core(w, ib) : 1'b0;
      3'd1: return (md != 2'd3) ? q : 1'b0;
      3'd2, 3'd3, 3'd4: begin
        t = (s + int'(code) - 1) % 4;
        return (md != 2'd1) ? ib[4*t+2] : 1'b0;
      end
      default: return 1'b0;
    endcase
  endfunction

  task automatic check_all(string ctx);
    logic [15:0] ib;
    ib = ibus();
    chk({ctx, " R5/R6/R12 c_out"}, c_out, act_m[14] ? 1'b0 : exp_core(act_m, ib));
    chk({ctx, " R7/R8/R13 q_out"}, q_out, q_m);
    chk({ctx, " R9/R10/R11 north"}, out_north, exp_side(act_m, ib, q_m, 0));
    chk({ctx, " R9/R12/R13 east"},  out_east,  exp_side(act_m, ib, q_m, 1));
    chk({ctx, " R4/R9 south"},      out_south, exp_side(act_m, ib, q_m, 2));
    chk({ctx, " R9/R10 west"},      out_west,  exp_side(act_m, ib, q_m, 3));
  endtask

  task automatic tick();
    logic nq, ld, en, din;
    nq  = ff_clr ? 1'b0 : ((act_m[14:13] != 2'd3) ? exp_core(act_m, ibus()) : q_m);
    ld  = cfg_load;
    en  = cfg_en;
    din = cfg_in;
    @(posedge clk);
    q_m = nq;
    if (ld) act_m = sh_m;
    if (en) sh_m = {sh_m[29:0], din};
    @(negedge clk);
    #1;
  endtask

  task automatic rand_in();
    in_north = 4'($urandom);
    in_east  = 4'($urandom);
    in_south = 4'($urandom);
    in_west  = 4'($urandom);
    #1;
  endtask

  task automatic load_word(logic [30:0] w);
    for (int k = 0; k < 31; k++) begin
      cfg_en = 1'b1;
      cfg_in = w[30-k];
      rand_in();
      chk("R2 cfg_out", cfg_out, sh_m[30]);
      check_all("R3 shifting");
      tick();
    end
    cfg_en = 1'b0;
    cfg_load = 1'b1;
    tick();
    cfg_load = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    logic [31:0] seed_v;
    logic [30:0] w;
    seed_v = $urandom(32'd4242);
    rst_n = 1'b0;
    in_north = '0; in_east = '0; in_south = '0; in_west = '0;
    cfg_en = 0; cfg_in = 0; cfg_load = 0; ff_clr = 0;
    sh_m = '0; act_m = '0; q_m = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 q_out in reset", q_out, 1'b0);
    chk("R1 north in reset", out_north, 1'b0);
    chk("R1 west in reset", out_west, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check_all("R1 after reset");

    // R8/R13: constant operand, route-only hold, clear during hold
    w = '0;
    w[4:0] = 5'd16; w[12] = 1'b1; w[11:10] = 2'd3;
    w[27] = 1'b1; w[15 +: 3] = 3'd1;
    load_word(w);
    tick();
    chk("R7 q loads constant", q_out, 1'b1);
    w[14:13] = 2'd3; w[12] = 1'b0; w[15 +: 3] = 3'd2;
    load_word(w);
    chk("R13 q held in route mode", q_out, 1'b1);
    check_all("R13 hold");
    ff_clr = 1'b1;
    tick();
    ff_clr = 1'b0;
    chk("R8 clear in route mode", q_out, 1'b0);

    // R2: idle shifting without enable leaves stage untouched
    load_word(31'h5A5A_3C3C);
    for (int k = 0; k < 6; k++) begin
      cfg_in = k[0];
      chk("R2 idle cfg_out", cfg_out, sh_m[30]);
      tick();
    end
    cfg_load = 1'b1;
    tick();
    cfg_load = 1'b0;
    check_all("R2 reload unchanged");

    // random configurations
    for (int n = 0; n < 150; n++) begin
      load_word(31'($urandom));
      for (int v = 0; v < 8; v++) begin
        rand_in();
        ff_clr = ($urandom % 8 == 0);
        check_all("R4 random");
        tick();
      end
      ff_clr = 1'b0;
    end

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end
endmodule